// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a four-wire serial slave that owns a bank of configuration registers and presents all of them at once on a flat parallel bus for neighbouring control logic. A host frames each transaction by pulling chip select low and clocking in sixteen bits. The first bit says whether the frame reads or writes. The next five bits name one of 32 registers, and the last ten bits carry data.

Writes take effect only when chip select returns high, and only if exactly sixteen serial clock rising edges were seen. During a read frame the addressed register is shifted out on the data-out pin, most significant bit first. The pin changes after falling serial clock edges, so the host can sample it on rising edges.

Every serial input passes through a two-flop synchronizer into the system clock domain. All framing logic runs on the system clock, which must be several times faster than the serial clock. The parallel register outputs come straight from flip-flops, so they never glitch. This block has no streaming data path and so no valid/ready pins. Its edge is a plain serial pin set and a static parallel bus, and it exerts no back-pressure.

Top module: `cfgsr_top`

## Requirements
- R1: A frame is the bits sampled on serial clock rising edges while chip select is low, most significant bit first. Frame bit 15 is the write flag (1 = write, 0 = read), bits 14:10 are the register address, and bits 9:0 are the data.
- R2: A write frame changes the addressed register only after chip select rises. The new value appears on the parallel bus within 8 system clock cycles of that rise, and the bus keeps its old value while chip select is still low.
- R3: A frame with fewer than 16 or more than 16 serial clock rising edges is discarded, and no register changes.
- R4: A read frame leaves every register unchanged.
- R5: In a read frame, the addressed register's ten bits appear on the data-out pin MSB first. Each bit is updated after a serial clock falling edge, starting with the falling edge after the sixth rising edge, so the host can sample bit 9 down to bit 0 just before rising edges 7 through 16.
- R6: The data-out pin is low whenever chip select has been high for at least 4 system clock cycles.
- R7: An asynchronous active-low reset loads register i with ((i*43) XOR 341) mod 1024 and drives the data-out pin low.
- R8: The parallel register bus changes only in the cycle after a committed write.
- R9: Each of the 32 addresses selects its own register. A write changes only the addressed register, and at most one register is written per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out, low when idle |
| cfg_flat | output | 320 | All registers, register i at bits i*10+9 : i*10 |

## Verification
The hardest case to reach is a frame whose count of serial edges is one short of or one past sixteen, while chip select timing is otherwise normal. The host task therefore takes any bit count and the bench confirms that the bus is untouched afterwards. Equally awkward is watching the bus while a valid write frame is complete but chip select is still low. For that, the task can leave chip select asserted, so the bench can compare the bus before it closes the frame by hand. Read-back values go through a scoreboard queue, so every address is compared against an independent model after a full write sweep.

// File: rtl/cfgsr_pkg.sv
package cfgsr_pkg;
  localparam int NREG   = 32;
  localparam int AW     = 5;
  localparam int DW     = 10;
  localparam int HDR    = 1 + AW;
  localparam int FL     = HDR + DW;
  localparam int CW     = $clog2(FL + 2);
  localparam int DEF_MUL = 43;
  localparam int DEF_XOR = 341;

  function automatic logic [DW-1:0] reg_default(input int idx);
    int v;
    v = (idx * DEF_MUL) ^ DEF_XOR;
    return DW'(v);
  endfunction
endpackage

// File: rtl/cfgsr_sync.sv
module cfgsr_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cfgsr_frame.sv
module cfgsr_frame
  import cfgsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_s,
  input  logic          sck_s,
  input  logic          din_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          dout
);
  logic          sck_q, cs_q;
  logic          sck_rise, sck_fall, cs_fall, cs_rise;
  logic [FL-1:0] sr_q, sr_next;
  logic [CW-1:0] cnt_q;
  logic          rd_active_q, load_pend_q;
  logic [DW-1:0] rd_sr_q;
  logic          hdr_done;

  assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_n_s;
  assign cs_fall  = ~cs_n_s & cs_q;
  assign cs_rise  = cs_n_s & ~cs_q;
  assign sr_next  = {sr_q[FL-2:0], din_s};
  assign hdr_done = sck_rise && (cnt_q == CW'(HDR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
    end
  end

  // bit counter saturates one past a full frame so long frames are rejected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      if (cs_fall)
        cnt_q <= '0;
      else if (sck_rise && cnt_q != CW'(FL + 1))
        cnt_q <= cnt_q + 1'b1;
      if (sck_rise)
        sr_q <= sr_next;
    end
  end

  // header capture and read-data load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active_q <= 1'b0;
      load_pend_q <= 1'b0;
      rd_addr     <= '0;
    end else begin
      load_pend_q <= hdr_done;
      if (cs_fall)
        rd_active_q <= 1'b0;
      else if (hdr_done)
        rd_active_q <= ~sr_next[AW];
      if (hdr_done)
        rd_addr <= sr_next[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sr_q <= '0;
      dout    <= 1'b0;
    end else if (cs_n_s) begin
      dout <= 1'b0;
    end else if (load_pend_q) begin
      rd_sr_q <= rd_data;
    end else if (sck_fall && rd_active_q &&
                 cnt_q >= CW'(HDR) && cnt_q < CW'(FL)) begin
      dout    <= rd_sr_q[DW-1];
      rd_sr_q <= {rd_sr_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb  <= cs_rise && (cnt_q == CW'(FL)) && sr_q[FL-1];
      wr_addr <= sr_q[FL-2 -: AW];
      wr_data <= sr_q[DW-1:0];
    end
  end

  // R6: data-out is low once chip select is seen high
  p_dout_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !dout);
  // R5: data-out only moves after a serial falling edge inside a frame
  p_dout_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_n_s) |=> $stable(dout));
  // R3: wrong-length frames never commit
  p_no_short_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt_q != CW'(FL)) |=> !wr_stb);
  // R4: read frames never commit
  p_read_no_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !sr_q[FL-1]) |=> !wr_stb);
  // R2: a commit only follows chip select going high
  p_commit_after_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> cs_q);
endmodule

// File: rtl/cfgsr_regbank.sv
module cfgsr_regbank
  import cfgsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] regs_flat
);
  logic [DW-1:0]   regs_q [NREG];
  logic [NREG-1:0] wr_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wr_vec[i] = wr_stb && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[i] <= reg_default(i);
      else if (wr_vec[i])
        regs_q[i] <= wr_data;
    end
    assign regs_flat[i*DW +: DW] = regs_q[i];
  end

  assign rd_data = regs_q[rd_addr];

  // R9: at most one register written per cycle
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  // R8: bus is stable without a write
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_flat));
endmodule

// File: rtl/cfgsr_top.sv
module cfgsr_top
  import cfgsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_cs_n,
  input  logic               ser_clk,
  input  logic               ser_din,
  output logic               ser_dout,
  output logic [NREG*DW-1:0] cfg_flat
);
  logic [2:0]    pins_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_stb;

  cfgsr_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_cs_n, ser_clk, ser_din}),
    .q     (pins_s)
  );

  cfgsr_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_s  (pins_s[2]),
    .sck_s   (pins_s[1]),
    .din_s   (pins_s[0]),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .dout    (ser_dout)
  );

  cfgsr_regbank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .regs_flat (cfg_flat)
  );

  // R2: the bus never changes while the external chip select has stayed low
  p_no_update_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_cs_n && $past(!ser_cs_n) && !pins_s[2]) |=> $stable(cfg_flat));
endmodule

// File: tb/cfgsr_top_tb.sv
module cfgsr_top_tb;
  localparam int NR = 32;
  localparam int H  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_cs_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout;
  logic [NR*10-1:0] cfg_flat;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [9:0] model [NR];
  logic [9:0] exp_q[$], got_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cfgsr_top u_dut (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .cfg_flat(cfg_flat)
  );

  function automatic logic [9:0] dflt(input int i);
    return 10'((i * 43) ^ 341);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input bit hold_cs,
                       output logic [9:0] rd);
    rd = '0;
    ser_cs_n = 1'b0;
    clks(H);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 16) ? w[15-i] : 1'b0;
      clks(H);
      if (i >= 6 && i < 16) rd[15-i] = ser_dout;
      ser_clk = 1'b1;
      clks(H);
      ser_clk = 1'b0;
    end
    clks(H);
    if (!hold_cs) begin
      ser_cs_n = 1'b1;
      clks(H);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [9:0] d);
    logic [9:0] unused;
    frame({1'b1, a, d}, 16, 1'b0, unused);
    model[a] = d;
  endtask

  task automatic do_read(input logic [4:0] a, input string req);
    logic [9:0] rd;
    frame({1'b0, a, 10'h2AA}, 16, 1'b0, rd);
    exp_q.push_back(model[a]);
    got_q.push_back(rd);
    tag_q.push_back(req);
  endtask

  task automatic check_bus(input string req);
    for (int i = 0; i < NR; i++) chk(req, 32'(cfg_flat[i*10 +: 10]), 32'(model[i]));
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [9:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(g), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] tmp;
    for (int i = 0; i < NR; i++) model[i] = dflt(i);
    clks(3);
    // R7: reset values and idle data-out
    check_bus("R7 reset default");
    chk("R7 dout after reset", 32'(ser_dout), 0);
    rst_n = 1'b1;
    clks(4);

    // R1 R2: basic writes
    do_write(5'd3, 10'h155);
    do_write(5'd31, 10'h3FF);
    do_write(5'd0, 10'h001);
    check_bus("R1 write decode");

    // R2: complete write frame held open, bus unchanged until cs rises
    frame({1'b1, 5'd7, 10'h0F0}, 16, 1'b1, tmp);
    chk("R2 no update before cs rise", 32'(cfg_flat[7*10 +: 10]), 32'(model[7]));
    ser_cs_n = 1'b1;
    clks(8);
    model[7] = 10'h0F0;
    chk("R2 update after cs rise", 32'(cfg_flat[7*10 +: 10]), 32'h0F0);

    // R3: short and long frames discarded
    frame({1'b1, 5'd9, 10'h123}, 15, 1'b0, tmp);
    check_bus("R3 short frame discarded");
    frame({1'b1, 5'd9, 10'h123}, 17, 1'b0, tmp);
    check_bus("R3 long frame discarded");
    frame({1'b1, 5'd9, 10'h123}, 0, 1'b0, tmp);
    check_bus("R3 empty frame discarded");

    // R5 R4: reads of written and default registers
    do_read(5'd3, "R5 read addr3");
    do_read(5'd31, "R5 read addr31");
    do_read(5'd12, "R5 read default addr12");
    check_bus("R4 reads leave bus unchanged");
    clks(4);
    chk("R6 dout idle after read", 32'(ser_dout), 0);

    // R9: sweep every address then read all back
    for (int i = 0; i < NR; i++) do_write(5'(i), 10'((i * 97 + 17) & 10'h3FF));
    check_bus("R9 all addresses");
    for (int i = 0; i < NR; i++) do_read(5'(i), "R9 R5 readback");
    do_write(5'd16, 10'h2C5);
    check_bus("R9 isolated write R8");
    do_read(5'd16, "R5 read after rewrite");
    clks(4);
    chk("R6 dout idle at end", 32'(ser_dout), 0);

    clks(10);
    chk("R5 scoreboard drained", 32'(got_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule